// File: doc/BRIEF.md
# 16-Bit Adder/Subtractor with Two-Level Carry Lookahead

This block is a purely combinational adder/subtractor for two 16-bit operands. It is built from four 4-bit lookahead groups. Each group forms bit-level generate and propagate terms, computes its internal carries directly from them, and reports a group generate and a group propagate upward. A second-level lookahead unit takes those group terms and the initial carry and produces the carry into every group, plus the final carry-out, in one expanded level of logic. No carry ripples from group to group.

A subtract control selects the operation. When it is set, every bit of the second operand passes through an XOR and is inverted, and the initial carry is inverted as well. The carry input therefore acts as a carry-in during addition and as a borrow-in during subtraction, so wider words can be chained. A signed overflow flag reports when the two's-complement result cannot be represented. The final carry-out is returned separately and plays no part in that flag.

Top module: `addsub_cla16`

## Requirements
- R1: With `sub_en`=0, `result` equals (`op_x` + `op_y` + `carry_in`) modulo 65536.
- R2: With `sub_en`=0, `carry_out` equals bit 16 of the unbounded sum `op_x` + `op_y` + `carry_in`.
- R3: With `sub_en`=1, `result` equals (`op_x` − `op_y` − `carry_in`) modulo 65536, so `carry_in` acts as a borrow-in.
- R4: With `sub_en`=1, `carry_out` is 1 exactly when `op_x` ≥ `op_y` + `carry_in`, both taken as unsigned values (no borrow).
- R5: `overflow` is 1 exactly when bit 15 of `op_x` equals bit 15 of the effective second operand (`op_y` in add mode, bitwise inverse of `op_y` in subtract mode) and bit 15 of `result` differs from them.
- R6: When the effective operands have different values in bit 15, `overflow` is 0 whether or not `carry_out` is 1.
- R7: A carry-out with no sign change does not set `overflow` (for example, 0xFFFF + 0xFFFF gives 0xFFFE, carry-out 1, overflow 0).
- R8: A carry created in or fed into a low group reaches every higher group through the lookahead unit, including a propagate across all 16 bits (0xFFFF + 0x0000 + carry-in 1 gives 0x0000 with carry-out 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | 16 | First operand |
| op_y | input | 16 | Second operand (subtrahend in subtract mode) |
| sub_en | input | 1 | 1 selects op_x − op_y, 0 selects op_x + op_y |
| carry_in | input | 1 | Carry-in when adding, borrow-in when subtracting |
| result | output | 16 | Sum or difference, modulo 65536 |
| carry_out | output | 1 | Carry out of bit 15 of the internal adder (1 means no borrow when subtracting) |
| overflow | output | 1 | Signed two's-complement overflow |

## Verification
The bench targets carries that must cross group boundaries, such as 0x000F + 1, 0x0FFF + 1 and a full-width propagate from the carry input. A second-level unit that drops a group term would return a result with a whole nibble left unincremented. It also walks the most negative value, the most positive value, all-ones and zero through both modes. A design that takes the overflow sign from the raw second operand rather than the inverted one would flag 0x8000 − 0x8000 and miss 0x0000 − 0x8000. Cases where a carry-out occurs without overflow, and cases where overflow occurs without a carry-out, catch a flag wrongly derived from the carry. Borrow-in subtractions catch a carry input that is not inverted in subtract mode.

// File: rtl/addsub_pkg.sv
// Package: shared sizing defaults and the generate/propagate pair type for
// the lookahead adder/subtractor. Assumes groups of equal width.
package addsub_pkg;

    localparam int DEF_GRP_W = 4;   // bits per lookahead group
    localparam int DEF_N_GRP = 4;   // number of groups

    // Generate/propagate pair reported by a lookahead group
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_pair_t;

endpackage

// File: rtl/cla_group.sv
// Module: cla_group
// One lookahead group. It forms bit generate (a AND b) and propagate
// (a OR b), derives every internal carry in expanded sum-of-products form
// from cin, returns the sum bits (3-input XOR) and the group-level generate
// and propagate. Assumes b is already conditioned for subtraction.
module cla_group #(
    parameter int W = 4
) (
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    input  logic                 cin,
    output logic [W-1:0]         sum,
    output addsub_pkg::gp_pair_t grp,
    output logic                 cout_local
);

    logic [W-1:0] bit_g;
    logic [W-1:0] bit_p;
    logic [W:0]   c;
    logic         prod;
    logic         gacc;
    logic         gprod;

    // Bit-level generate and propagate terms
    always_comb begin
        bit_g = a & b;
        bit_p = a | b;
    end

    // Internal carries: each is OR of (source term AND all higher propagates)
    always_comb begin
        c    = '0;
        c[0] = cin;
        prod = 1'b0;
        for (int i = 1; i <= W; i++) begin
            c[i] = 1'b0;
            for (int j = -1; j < i; j++) begin
                prod = (j < 0) ? cin : bit_g[j];
                for (int k = j + 1; k < i; k++) begin
                    prod = prod & bit_p[k];
                end
                c[i] = c[i] | prod;
            end
        end
    end

    // Sum bits from operands and incoming carries
    always_comb begin
        sum        = a ^ b ^ c[W-1:0];
        cout_local = c[W];
    end

    // Group generate (carry independent of cin) and group propagate
    always_comb begin
        gacc  = 1'b0;
        gprod = 1'b0;
        for (int j = 0; j < W; j++) begin
            gprod = bit_g[j];
            for (int k = j + 1; k < W; k++) begin
                gprod = gprod & bit_p[k];
            end
            gacc = gacc | gprod;
        end
        grp.gen  = gacc;
        grp.prop = &bit_p;
    end

    // Group terms must agree with the bit-level carry chain
    always_comb begin
        AST_GROUP_GP: assert (cout_local == (grp.gen | (grp.prop & cin)))
            else $error("group G/P disagree with local carry");  // R8
        if (grp.gen) begin
            AST_GROUP_GEN: assert (cout_local)
                else $error("group generate without carry-out");  // R8
        end
    end

endmodule

// File: rtl/cla_lookahead.sv
// Module: cla_lookahead
// Second-level lookahead. From the group generate/propagate pairs and the
// initial carry it forms the carry into every group and the final carry,
// each as one expanded sum of products (no group-to-group ripple).
module cla_lookahead #(
    parameter int N = 4
) (
    input  addsub_pkg::gp_pair_t [N-1:0] grp,
    input  logic                         c0,
    output logic [N:0]                   carry
);

    logic [N-1:0] gg;
    logic [N-1:0] gp;
    logic         prod;

    // Unpack group pairs into separate vectors
    always_comb begin
        for (int k = 0; k < N; k++) begin
            gg[k] = grp[k].gen;
            gp[k] = grp[k].prop;
        end
    end

    // Expanded second-level carries
    always_comb begin
        carry    = '0;
        carry[0] = c0;
        prod     = 1'b0;
        for (int i = 1; i <= N; i++) begin
            carry[i] = 1'b0;
            for (int j = -1; j < i; j++) begin
                prod = (j < 0) ? c0 : gg[j];
                for (int k = j + 1; k < i; k++) begin
                    prod = prod & gp[k];
                end
                carry[i] = carry[i] | prod;
            end
        end
    end

    // Flat carries must match the one-step recurrence between groups
    always_comb begin
        for (int k = 0; k < N; k++) begin
            AST_LA_CHAIN: assert (carry[k+1] == (gg[k] | (gp[k] & carry[k])))
                else $error("lookahead carry %0d inconsistent", k + 1);  // R8
        end
    end

endmodule

// File: rtl/addsub_cla16.sv
// Module: addsub_cla16
// Top of the adder/subtractor. Conditions the second operand with XOR for
// subtraction, inverts the carry input in subtract mode, instantiates the
// groups and the second-level lookahead, and forms carry-out and signed
// overflow. Purely combinational; no clock or reset is needed.
module addsub_cla16 #(
    parameter int GRP_W = addsub_pkg::DEF_GRP_W,
    parameter int N_GRP = addsub_pkg::DEF_N_GRP
) (
    input  logic [GRP_W*N_GRP-1:0] op_x,
    input  logic [GRP_W*N_GRP-1:0] op_y,
    input  logic                   sub_en,
    input  logic                   carry_in,
    output logic [GRP_W*N_GRP-1:0] result,
    output logic                   carry_out,
    output logic                   overflow
);

    localparam int WIDTH = GRP_W * N_GRP;
    localparam int MSB   = WIDTH - 1;

    logic [WIDTH-1:0]                   y_eff;
    logic                               c0;
    logic [N_GRP:0]                     grp_carry;
    logic [N_GRP-1:0]                   local_cout;
    addsub_pkg::gp_pair_t [N_GRP-1:0]   grp_terms;

    // Operand conditioning: invert Y and the carry input when subtracting
    always_comb begin
        y_eff = op_y ^ {WIDTH{sub_en}};
        c0    = carry_in ^ sub_en;
    end

    // One lookahead group per slice of the word
    for (genvar gi = 0; gi < N_GRP; gi++) begin : g_grp
        cla_group #(
            .W(GRP_W)
        ) i_group (
            .a          (op_x[gi*GRP_W +: GRP_W]),
            .b          (y_eff[gi*GRP_W +: GRP_W]),
            .cin        (grp_carry[gi]),
            .sum        (result[gi*GRP_W +: GRP_W]),
            .grp        (grp_terms[gi]),
            .cout_local (local_cout[gi])
        );

        // A group's own carry-out must equal the lookahead carry above it
        always_comb begin
            AST_GROUP_CARRY: assert (local_cout[gi] == grp_carry[gi+1])
                else $error("group %0d carry mismatch", gi);  // R8
        end
    end

    cla_lookahead #(
        .N(N_GRP)
    ) i_lookahead (
        .grp   (grp_terms),
        .c0    (c0),
        .carry (grp_carry)
    );

    // Carry-out and signed overflow from the sign bits
    always_comb begin
        carry_out = grp_carry[N_GRP];
        overflow  = (op_x[MSB] == y_eff[MSB]) && (result[MSB] != op_x[MSB]);
    end

    // Overflow sanity against operand and result signs
    always_comb begin
        if (op_x[MSB] != y_eff[MSB]) begin
            AST_NO_OVERFLOW: assert (!overflow)
                else $error("overflow with opposite signs");  // R6
        end
        if (overflow) begin
            AST_OVF_SIGN: assert (result[MSB] != op_x[MSB])
                else $error("overflow without sign change");  // R5
        end
    end

endmodule

// File: tb/test_addsub_cla16.sv
// Directed bench for addsub_cla16; expected values from a behavioural model.
module test_addsub_cla16;

    logic        clk = 1'b0;
    logic [15:0] op_x = '0;
    logic [15:0] op_y = '0;
    logic        sub_en = 1'b0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        carry_out;
    logic        overflow;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    addsub_cla16 i_addsub_cla16 (
        .op_x      (op_x),
        .op_y      (op_y),
        .sub_en    (sub_en),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected < 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Drive one vector, compute the expected outputs, compare all three
    task automatic apply(input logic [15:0] x, input logic [15:0] y,
                         input logic s, input logic ci, input string tag);
        logic [15:0] ye;
        logic [16:0] full;
        logic        exp_ovf;
        ye      = s ? ~y : y;
        full    = {1'b0, x} + {1'b0, ye} + {16'b0, ci ^ s};
        exp_ovf = (x[15] == ye[15]) && (full[15] != x[15]);
        @(negedge clk);
        op_x = x; op_y = y; sub_en = s; carry_in = ci;
        #2;
        n_checks++;
        if (result !== full[15:0]) begin
            n_fail++;
            $display("FAIL %s result x=%h y=%h sub=%0d cin=%0d: actual %h expected %h",
                     tag, x, y, s, ci, result, full[15:0]);
        end
        n_checks++;
        if (carry_out !== full[16]) begin
            n_fail++;
            $display("FAIL %s carry x=%h y=%h sub=%0d cin=%0d: actual %0d expected %0d",
                     tag, x, y, s, ci, carry_out, full[16]);
        end
        n_checks++;
        if (overflow !== exp_ovf) begin
            n_fail++;
            $display("FAIL %s overflow x=%h y=%h sub=%0d cin=%0d: actual %0d expected %0d",
                     tag, x, y, s, ci, overflow, exp_ovf);
        end
    endtask

    // Hand-computed value check for key cases
    task automatic expect_val(input logic [15:0] r, input logic co, input logic ov,
                              input string tag);
        n_checks++;
        if (result !== r || carry_out !== co || overflow !== ov) begin
            n_fail++;
            $display("FAIL %s: actual %h/%0d/%0d expected %h/%0d/%0d",
                     tag, result, carry_out, overflow, r, co, ov);
        end
    endtask

    task automatic t_idle();
        apply(16'h0000, 16'h0000, 1'b0, 1'b0, "R1 idle");
        expect_val(16'h0000, 1'b0, 1'b0, "R1 idle");
    endtask

    task automatic t_add();
        apply(16'h1234, 16'h4321, 1'b0, 1'b0, "R1");
        expect_val(16'h5555, 1'b0, 1'b0, "R1 plain add");
        apply(16'h1234, 16'h4321, 1'b0, 1'b1, "R1 cin");
        expect_val(16'h5556, 1'b0, 1'b0, "R1 carry-in");
        apply(16'hFFFF, 16'h0001, 1'b0, 1'b0, "R2");
        expect_val(16'h0000, 1'b1, 1'b0, "R2 wrap carry");
    endtask

    task automatic t_group_carry();
        apply(16'h000F, 16'h0001, 1'b0, 1'b0, "R8 g0->g1");
        expect_val(16'h0010, 1'b0, 1'b0, "R8 g0->g1");
        apply(16'h00FF, 16'h0001, 1'b0, 1'b0, "R8 g0->g2");
        apply(16'h0FFF, 16'h0001, 1'b0, 1'b0, "R8 g0->g3");
        expect_val(16'h1000, 1'b0, 1'b0, "R8 g0->g3");
        apply(16'hFFFF, 16'h0000, 1'b0, 1'b1, "R8 full propagate");
        expect_val(16'h0000, 1'b1, 1'b0, "R8 full propagate");
        apply(16'hF0F0, 16'h0F10, 1'b0, 1'b0, "R8 mixed");
    endtask

    task automatic t_sub();
        apply(16'h0005, 16'h0003, 1'b1, 1'b0, "R3");
        expect_val(16'h0002, 1'b1, 1'b0, "R3 R4 5-3");
        apply(16'h0003, 16'h0005, 1'b1, 1'b0, "R3");
        expect_val(16'hFFFE, 1'b0, 1'b0, "R3 R4 3-5");
        apply(16'h0005, 16'h0003, 1'b1, 1'b1, "R3 borrow-in");
        expect_val(16'h0001, 1'b1, 1'b0, "R3 borrow-in");
        apply(16'h0000, 16'h0000, 1'b1, 1'b1, "R4 borrow-in");
        expect_val(16'hFFFF, 1'b0, 1'b0, "R4 0-0-1");
        apply(16'hABCD, 16'hABCD, 1'b1, 1'b0, "R4 equal");
        expect_val(16'h0000, 1'b1, 1'b0, "R4 x-x");
    endtask

    task automatic t_overflow();
        apply(16'h7FFF, 16'h0001, 1'b0, 1'b0, "R5");
        expect_val(16'h8000, 1'b0, 1'b1, "R5 max+1");
        apply(16'h8000, 16'h8000, 1'b0, 1'b0, "R5");
        expect_val(16'h0000, 1'b1, 1'b1, "R5 min+min");
        apply(16'h8000, 16'h0001, 1'b1, 1'b0, "R5");
        expect_val(16'h7FFF, 1'b1, 1'b1, "R5 min-1");
        apply(16'h0000, 16'h8000, 1'b1, 1'b0, "R5");
        expect_val(16'h8000, 1'b0, 1'b1, "R5 0-min");
        apply(16'h7FFF, 16'hFFFF, 1'b1, 1'b0, "R5 max-(-1)");
    endtask

    task automatic t_no_overflow();
        apply(16'h7FFF, 16'hFFFF, 1'b0, 1'b0, "R6");
        expect_val(16'h7FFE, 1'b1, 1'b0, "R6 opposite with carry");
        apply(16'h8000, 16'h7FFF, 1'b0, 1'b0, "R6");
        expect_val(16'hFFFF, 1'b0, 1'b0, "R6 opposite no carry");
        apply(16'h8000, 16'h8000, 1'b1, 1'b0, "R6 min-min");
        expect_val(16'h0000, 1'b1, 1'b0, "R6 min-min");
        apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, "R7");
        expect_val(16'hFFFE, 1'b1, 1'b0, "R7 carry without overflow");
    endtask

    task automatic t_corners();
        logic [15:0] vals [5];
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
        vals[3] = 16'h8000; vals[4] = 16'hFFFF;
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int m = 0; m < 4; m++)
                    apply(vals[i], vals[j], m[1], m[0], "R5 corner");
    endtask

    task automatic t_random();
        for (int n = 0; n < 400; n++) begin
            logic [15:0] rx;
            logic [15:0] ry;
            logic [1:0]  rm;
            rx = 16'($urandom);
            ry = 16'($urandom);
            rm = 2'($urandom);
            apply(rx, ry, rm[1], rm[0], rm[1] ? "R3 R4 random" : "R1 R2 random");
        end
    endtask

    initial begin
        t_idle();
        t_add();
        t_group_carry();
        t_sub();
        t_overflow();
        t_no_overflow();
        t_corners();
        t_random();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule